// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes to a smart card over one shared open-drain data line and repeats a byte when the card reports an error. Bytes come in on a valid/ready stream input. For each byte the block pulls the line low for a start bit. It then sends the eight data bits, least significant first, and after them an even parity bit. Every bit lasts a programmable number of clock cycles. After the parity bit the block releases the line. The external pull-up holds a released line high. The block itself only ever pulls low or lets go.

After the frame the block keeps the line released and samples it once inside the guard window. If the card holds the line low at that point, it is signalling an error, and the block sends the identical byte again from the start bit. A configurable limit caps the number of resends. When a byte is still refused after the last allowed resend, the block raises a failure pulse and drops the byte. Single-cycle status pulses report delivery, resend and failure.

Back-pressure is simple. `in_ready` is high only while no byte is in flight. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the byte is delivered or dropped. The two configuration inputs are captured at acceptance and apply to that byte and all of its resends. `line_in` is assumed to be already synchronous to `clk`.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, `in_ready` is 1, `line_drive_low` is 0, and `done_pulse`, `retry_pulse` and `fail_pulse` are all 0.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for every cycle until the cycle that carries the byte's done or fail pulse, in which it is 1 again.
- R3: Let D be the captured `cfg_etu_div` (D >= 2). Frame slot k occupies cycles k*D to k*D+D-1, counted from the first cycle after acceptance. Slot 0 is the start bit, with `line_drive_low`=1. Slots 1 to 8 carry data bits D0 to D7 in that order, and `line_drive_low` is the inverse of the bit.
- R4: Slot 9 carries the parity bit, chosen so that the count of ones in D0 to D7 plus parity is even. `line_drive_low` is the inverse of the parity bit.
- R5: `line_drive_low` is 0 throughout slots 10 to 13. This gives at least two bit periods of released line after the error sample and before any next start bit.
- R6: `line_in` is sampled on the rising edge that ends cycle 11*D of the frame. A 0 there counts as an error signal.
- R7: If no error was sampled, `done_pulse` is 1 for exactly the cycle 14*D, and the block is idle and ready in that cycle.
- R8: If an error was sampled and fewer than the captured `cfg_max_retry` resends have been made, `retry_pulse` is 1 in cycle 14*D. That cycle is slot 0 of a resend of the same byte.
- R9: If an error was sampled and the captured `cfg_max_retry` resends have already been made, `fail_pulse` is 1 for cycle 14*D. The byte is dropped, and the block is ready in that cycle. At most one of the three pulses is high in any cycle.
- R10: A low on `line_in` at any cycle other than the sample point of R6 has no effect on the outcome.
- R11: Changes to `cfg_etu_div` or `cfg_max_retry` after acceptance do not affect the byte in flight or its resends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_etu_div | input | DIV_W | Bit period in clock cycles, captured at acceptance |
| cfg_max_retry | input | RETRY_W | Maximum number of resends per byte, captured at acceptance |
| in_valid | input | 1 | Byte offered on `in_data` |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Byte to send |
| line_in | input | 1 | Level seen on the shared data line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| done_pulse | output | 1 | Byte delivered without error |
| retry_pulse | output | 1 | Error seen, resend starting |
| fail_pulse | output | 1 | Error after the last allowed resend, byte dropped |

## Verification
The bench keeps the default widths (DIV_W=8, RETRY_W=3) and varies the runtime configuration. All 256 byte values go through with a 4-cycle bit period, which covers every data and parity pattern bit by bit. With a 5-cycle bit period and resend limits of 0, 1 and 2, every number of refused frames from none up to one past the limit is exercised. That reaches both the resend path and the drop path. A late card pulse that misses the sample point and configuration changes made mid-byte are also checked.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic { ST_IDLE, ST_SEND } tx_state_t;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned SAMPLE_ETU = 11;
  localparam int unsigned LAST_ETU   = 13;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer
  import sc_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  input  logic             restart,
  output logic [IDX_W-1:0] etu_idx,
  output logic             at_sample,
  output logic             at_end
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_cyc;

  assign last_cyc  = (cnt_q == div_q - 1'b1);
  assign etu_idx   = idx_q;
  assign at_sample = run && (idx_q == IDX_W'(SAMPLE_ETU)) && (cnt_q == '0);
  assign at_end    = run && (idx_q == IDX_W'(LAST_ETU)) && last_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      if (load) div_q <= div_in;
      if (restart) begin
        cnt_q <= '0;
        idx_q <= '0;
      end else if (run) begin
        if (last_cyc) begin
          cnt_q <= '0;
          idx_q <= idx_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3: the cycle counter never runs past the captured bit period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(load)) |-> (cnt_q < div_q));

  // R5: the slot index never leaves the 14-slot frame
  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx_q <= IDX_W'(LAST_ETU)));
endmodule

// File: rtl/sc_frame_reg.sv
module sc_frame_reg
  import sc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              active,
  input  logic [IDX_W-1:0]  etu_idx,
  output logic              drive_low
);
  localparam int unsigned SLOTS = 1 << IDX_W;
  localparam int unsigned PAD   = SLOTS - BYTE_W - 2;

  logic [BYTE_W-1:0] byte_q;
  logic [SLOTS-1:0]  line_pattern;

  always_ff @(posedge clk) begin
    if (!rst_n) byte_q <= '0;
    else if (load) byte_q <= data_in;
  end

  // slot 0 start (0), slots 1..8 data LSB first, slot 9 even parity, rest released (1)
  assign line_pattern = {{PAD{1'b1}}, ^byte_q, byte_q, 1'b0};
  assign drive_low    = active && !line_pattern[etu_idx];

  // R3: the start slot always pulls the line low
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && etu_idx == '0) |-> drive_low);
endmodule

// File: rtl/sc_retry_ctr.sv
module sc_retry_ctr #(
  parameter int unsigned RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RETRY_W-1:0] max_in,
  input  logic               bump,
  output logic               may_retry
);
  logic [RETRY_W-1:0] max_q;
  logic [RETRY_W-1:0] used_q;

  assign may_retry = (used_q < max_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_q  <= '0;
      used_q <= '0;
    end else if (load) begin
      max_q  <= max_in;
      used_q <= '0;
    end else if (bump) begin
      used_q <= used_q + 1'b1;
    end
  end

  // R9: resends never exceed the captured limit
  p_retry_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= max_q);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_etu_div,
  input  logic [RETRY_W-1:0] cfg_max_retry,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               line_in,
  output logic               line_drive_low,
  output logic               done_pulse,
  output logic               retry_pulse,
  output logic               fail_pulse
);
  tx_state_t        state_q;
  logic             accept, run, restart, resend;
  logic             at_sample, at_end, may_retry;
  logic             err_q;
  logic [IDX_W-1:0] etu_idx;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign run      = (state_q == ST_SEND);
  assign resend   = at_end && err_q && may_retry;
  assign restart  = accept || resend;

  sc_etu_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .div_in(cfg_etu_div),
    .run(run), .restart(restart), .etu_idx(etu_idx),
    .at_sample(at_sample), .at_end(at_end)
  );

  sc_frame_reg u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .data_in(in_data),
    .active(run), .etu_idx(etu_idx), .drive_low(line_drive_low)
  );

  sc_retry_ctr #(.RETRY_W(RETRY_W)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(accept), .max_in(cfg_max_retry),
    .bump(resend), .may_retry(may_retry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      err_q       <= 1'b0;
      done_pulse  <= 1'b0;
      retry_pulse <= 1'b0;
      fail_pulse  <= 1'b0;
    end else begin
      done_pulse  <= 1'b0;
      retry_pulse <= 1'b0;
      fail_pulse  <= 1'b0;
      if (restart)        err_q <= 1'b0;
      else if (at_sample) err_q <= !line_in;
      if (accept) state_q <= ST_SEND;
      if (at_end) begin
        if (!err_q) begin
          done_pulse <= 1'b1;
          state_q    <= ST_IDLE;
        end else if (may_retry) begin
          retry_pulse <= 1'b1;
        end else begin
          fail_pulse <= 1'b1;
          state_q    <= ST_IDLE;
        end
      end
    end
  end

  // R9: status pulses are mutually exclusive
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, retry_pulse, fail_pulse}));
  // R2: acceptance removes ready on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R3: the start bit follows acceptance at once
  p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> line_drive_low);
  // R8: a resend begins with its start bit in the pulse cycle
  p_retry_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> (line_drive_low && !in_ready));
  // R7: delivery leaves the block ready with the line released
  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (in_ready && !line_drive_low));
  // R9: a dropped byte leaves the block ready with the line released
  p_fail_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> (in_ready && !line_drive_low));
endmodule

// File: tb/test_sc_char_tx.sv
module test_sc_char_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_etu_div = 8'd4;
  logic [2:0] cfg_max_retry = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       line_in;
  logic       line_drive_low;
  logic       done_pulse, retry_pulse, fail_pulse;
  logic       card_low = 1'b0;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  assign line_in = ~(line_drive_low | card_low);

  sc_char_tx i_sc_char_tx (
    .clk(clk), .rst_n(rst_n), .cfg_etu_div(cfg_etu_div),
    .cfg_max_retry(cfg_max_retry), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .line_in(line_in), .line_drive_low(line_drive_low),
    .done_pulse(done_pulse), .retry_pulse(retry_pulse), .fail_pulse(fail_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // mode: 0 = card signals error on the first nerr frames, 1 = late low pulse only (R10)
  task automatic send_byte(input logic [7:0] b, input int d, input int maxr,
                           input int nerr, input int mode, input bit cfg_chg);
    int frames;
    bit fails;
    fails  = (mode == 0) && (nerr > maxr);
    frames = (mode != 0) ? 1 : (fails ? maxr + 1 : nerr + 1);
    @(negedge clk);
    cfg_etu_div   = 8'(d);
    cfg_max_retry = 3'(maxr);
    in_data       = b;
    in_valid      = 1'b1;
    check("R2 ready before accept", int'(in_ready), 1);
    for (int f = 0; f < frames; f++) begin
      for (int t = 0; t < 14 * d; t++) begin
        @(negedge clk);
        if (t == 0) begin
          in_valid = 1'b0;
          in_data  = ~b;
          if (cfg_chg) begin
            cfg_etu_div   = 8'(d + 3);
            cfg_max_retry = 3'(maxr == 0 ? 1 : 0);
          end
          check("R8 retry pulse at frame start", int'(retry_pulse), (f > 0) ? 1 : 0);
        end else begin
          check("R9 no pulse inside frame",
                int'(done_pulse) + int'(retry_pulse) + int'(fail_pulse), 0);
        end
        if (mode == 0)
          card_low = (f < nerr) && (t >= 10 * d + d / 2) && (t < 12 * d);
        else
          card_low = (t >= 12 * d) && (t < 13 * d);
        check("R2 busy during frame", int'(in_ready), 0);
        if (t % d == d / 2) begin
          int k;
          int e;
          k = t / d;
          if (k == 0)      e = 1;
          else if (k <= 8) e = b[k-1] ? 0 : 1;
          else if (k == 9) e = (^b) ? 0 : 1;
          else             e = 0;
          if (k <= 8)      check("R3 frame bit", int'(line_drive_low), e);
          else if (k == 9) check("R4 parity bit", int'(line_drive_low), e);
          else             check("R5 released in guard", int'(line_drive_low), e);
        end
      end
    end
    @(negedge clk);
    card_low = 1'b0;
    if (cfg_chg) begin
      check("R11 config change ignored done", int'(done_pulse), (nerr == 0) ? 1 : 0);
      check("R11 config change ignored fail", int'(fail_pulse), fails ? 1 : 0);
    end else if (mode != 0) begin
      check("R10 late low ignored", int'(done_pulse), 1);
    end else begin
      check("R7 done pulse", int'(done_pulse), fails ? 0 : 1);
      check("R9 fail pulse", int'(fail_pulse), fails ? 1 : 0);
    end
    check("R6 no resend after outcome", int'(retry_pulse), 0);
    check("R2 ready after outcome", int'(in_ready), 1);
    check("R5 line released", int'(line_drive_low), 0);
    @(negedge clk);
    check("R7 pulse lasts one cycle",
          int'(done_pulse) + int'(fail_pulse) + int'(retry_pulse), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 1);
    check("R1 line released after reset", int'(line_drive_low), 0);
    check("R1 pulses low after reset",
          int'(done_pulse) + int'(retry_pulse) + int'(fail_pulse), 0);
    for (int v = 0; v < 256; v++)
      send_byte(8'(v), 4, 2, 0, 0, 1'b0);
    for (int m = 0; m <= 2; m++)
      for (int n = 0; n <= m + 1; n++)
        send_byte(8'h5A ^ 8'(m * 16 + n), 5, m, n, 0, 1'b0);
    send_byte(8'hC3, 5, 1, 0, 1, 1'b0);
    send_byte(8'h96, 6, 0, 0, 0, 1'b1);
    send_byte(8'h3C, 4, 1, 2, 0, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule